// File: doc/BRIEF.md
# Settled Pin Response Checker

This block is the result stage of a vector-driven tester for small digital parts. A decoder upstream drives a test vector onto the part's pins and then pulses `vec_done`. The block captures the role and expected level of every pin with that pulse. It waits a programmable number of clocks so that the part's outputs can settle. It then compares the synchronized pin levels against the expectations. Only pins whose role is "output" and whose expected level is a definite 1 or 0 take part in the comparison.

For each compared vector the block reports a pass/fail flag and a mask with one bit per pin position. A mask bit is set for each pin that mismatched, so a failing result shows which pins are faulty. A failing vector also raises a one-cycle alarm request for an audible indicator. The block also formats a short result record and writes it byte by byte into a transmit FIFO that leads to the host. If the FIFO is full, the write waits, and no byte is ever lost.

Top module: `pin_response_checker`

## Requirements
- R1: The compare happens exactly `SETTLE_CYC` clock edges after the edge that samples `vec_done`. `result_valid` is high for one cycle after that compare edge. A new `vec_done` during the wait restarts the count from that pulse.
- R2: Each pin has a 2-bit role field at bits [2i+1:2i] of `pin_role`: 00 input, 01 power, 10 output, 11 unknown. Each pin has a 2-bit expected level at the same position in `pin_expect`: 00 undetermined, 01 one, 10 zero, 11 high impedance. A pin is compared only when its role is 10 and its expected level is 01 or 10. Any other pin can never be flagged.
- R3: Bit i of `fault_mask` is set exactly when pin i is compared and its synchronized level differs from its expectation. `result_fail` is the OR of the mask. Both keep their values until the next compare.
- R4: Each compare produces a record of 4 bytes, written in this order. Byte 0 is the status byte: bit 0 is fail, bits 5:1 are the `vec_index` captured with `vec_done`, and bits 7:6 are 0. Bytes 1 to 3 hold `fault_mask` bits 7:0, 15:8 and 19:16, and the upper 4 bits of byte 3 are 0.
- R5: `fifo_wr` is never high while `fifo_full` is high. While a byte is stalled, `fifo_data` holds its value. Every record byte is written exactly once.
- R6: `alarm` pulses for exactly one cycle, together with `result_valid`, for each failing vector. It stays low for a passing vector.
- R7: A compare whose settling time has ended while the previous record is still being written waits until that record is complete. No record is overwritten.
- R8: After reset, `result_valid`, `result_fail`, `fault_mask`, `alarm` and `fifo_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_done | input | 1 | Pulse: a vector has just been applied |
| vec_index | input | 5 | Index of the applied vector |
| pin_role | input | 40 | Two role bits per pin |
| pin_expect | input | 40 | Two expected-level bits per pin |
| pin_in | input | 20 | Asynchronous levels read back from the pins |
| result_valid | output | 1 | One-cycle pulse after each compare |
| result_fail | output | 1 | Last compare found a mismatch |
| fault_mask | output | 20 | Per-pin mismatch flags of the last compare |
| alarm | output | 1 | One-cycle alarm request on a failing vector |
| fifo_full | input | 1 | Transmit FIFO cannot accept a byte |
| fifo_wr | output | 1 | Write strobe for the transmit FIFO |
| fifo_data | output | 8 | Record byte being written |

## Verification
A settling counter that is off by one would move `result_valid` by one cycle relative to the `vec_done` edge. Because the result timing is checked cycle-exactly, that error shows on the very first vector. A wrong per-pin qualification shows as a mask bit that is set or cleared at one specific pin position. The sweep flips one pin at a time and pairs every role with every level, so the bad position is named within one vector. A byte counter or record register that goes wrong in the output stage shows as a missing, repeated or reordered byte in the host stream. A record that is overwritten shows in the same stream. Such an error appears within the few cycles after a stalled or back-to-back result.

// File: rtl/pin_chk_pkg.sv
package pin_chk_pkg;
   typedef enum logic [1:0] {
      ROLE_IN  = 2'b00,
      ROLE_PWR = 2'b01,
      ROLE_OUT = 2'b10,
      ROLE_UNK = 2'b11
   } pin_role_e;

   typedef enum logic [1:0] {
      LVL_UNDEF = 2'b00,
      LVL_ONE   = 2'b01,
      LVL_ZERO  = 2'b10,
      LVL_HIZ   = 2'b11
   } pin_level_e;

   localparam int STATUS_FAIL_BIT = 0;
   localparam int STATUS_IDX_LSB  = 1;
endpackage

// File: rtl/pc_sync.sv
module pc_sync #(
   parameter int W      = 20,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '0;
            else if (s == 0) stage[s] <= d;
            else stage[s] <= stage[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/pc_settle_timer.sv
module pc_settle_timer #(
   parameter int CYCLES = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic hold,
   output logic expire
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt;

   assign expire = (cnt == ONE) && !start && !hold;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (start)       cnt <= LOAD;
      else if (cnt > ONE)   cnt <= cnt - ONE;
      else if (expire)      cnt <= '0;
   end
endmodule

// File: rtl/pc_mismatch.sv
module pc_mismatch
   import pin_chk_pkg::*;
#(
   parameter int PINS = 20
) (
   input  logic [2*PINS-1:0] role,
   input  logic [2*PINS-1:0] expect_lvl,
   input  logic [PINS-1:0]   pins,
   output logic [PINS-1:0]   mask
);
   generate
      for (genvar i = 0; i < PINS; i++) begin : g_pin
         pin_role_e  r;
         pin_level_e e;
         logic       checked;
         assign r       = pin_role_e'(role[2*i +: 2]);
         assign e       = pin_level_e'(expect_lvl[2*i +: 2]);
         assign checked = (r == ROLE_OUT) && ((e == LVL_ONE) || (e == LVL_ZERO));
         assign mask[i] = checked && (pins[i] != (e == LVL_ONE));
      end
   endgenerate
endmodule

// File: rtl/pc_record_emitter.sv
module pc_record_emitter
   import pin_chk_pkg::*;
#(
   parameter int PINS  = 20,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             fail,
   input  logic [IDX_W-1:0] idx,
   input  logic [PINS-1:0]  mask,
   input  logic             fifo_full,
   output logic             fifo_wr,
   output logic [7:0]       fifo_data,
   output logic             busy
);
   localparam int MASK_BYTES = (PINS + 7) / 8;
   localparam int NBYTES     = 1 + MASK_BYTES;
   localparam int BW         = $clog2(NBYTES + 1);
   localparam logic [BW-1:0] LAST = BW'(NBYTES - 1);

   logic [8*NBYTES-1:0]    rec;
   logic [8*NBYTES-1:0]    rec_next;
   logic [8*MASK_BYTES-1:0] mask_ext;
   logic [7:0]             status;
   logic [BW-1:0]          pos;

   always_comb begin
      mask_ext = '0;
      mask_ext[PINS-1:0] = mask;
      status = '0;
      status[STATUS_FAIL_BIT] = fail;
      status[STATUS_IDX_LSB +: IDX_W] = idx;
      rec_next = {mask_ext, status};
   end

   assign fifo_wr   = busy && !fifo_full;
   assign fifo_data = rec[7:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         pos  <= '0;
         rec  <= '0;
      end else if (load && !busy) begin
         busy <= 1'b1;
         pos  <= '0;
         rec  <= rec_next;
      end else if (fifo_wr) begin
         rec <= rec >> 8;
         pos <= pos + BW'(1);
         if (pos == LAST) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/pin_response_checker.sv
module pin_response_checker
   import pin_chk_pkg::*;
#(
   parameter int PINS        = 20,
   parameter int IDX_W       = 5,
   parameter int SETTLE_CYC  = 50000,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vec_done,
   input  logic [IDX_W-1:0]   vec_index,
   input  logic [2*PINS-1:0]  pin_role,
   input  logic [2*PINS-1:0]  pin_expect,
   input  logic [PINS-1:0]    pin_in,
   output logic               result_valid,
   output logic               result_fail,
   output logic [PINS-1:0]    fault_mask,
   output logic               alarm,
   input  logic               fifo_full,
   output logic               fifo_wr,
   output logic [7:0]         fifo_data
);
   generate
      if (PINS < 1 || PINS > 64) begin : g_bad_pins
         $error("PINS out of range");
      end
      if (IDX_W < 1 || IDX_W > 7 - STATUS_IDX_LSB + 1) begin : g_bad_idx
         $error("IDX_W does not fit the status byte");
      end
      if (SETTLE_CYC < 2) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PINS-1:0]   pin_sync;
   logic [2*PINS-1:0] role_q;
   logic [2*PINS-1:0] expect_q;
   logic [IDX_W-1:0]  idx_q;
   logic [PINS-1:0]   mism;
   logic              fire;
   logic              emit_busy;

   pc_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   pc_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(vec_done), .hold(emit_busy), .expire(fire)
   );

   pc_mismatch #(.PINS(PINS)) u_cmp (
      .role(role_q), .expect_lvl(expect_q), .pins(pin_sync), .mask(mism)
   );

   pc_record_emitter #(.PINS(PINS), .IDX_W(IDX_W)) u_emit (
      .clk(clk), .rst_n(rst_n), .load(fire), .fail(|mism), .idx(idx_q),
      .mask(mism), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
      .fifo_data(fifo_data), .busy(emit_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         role_q   <= '0;
         expect_q <= '0;
         idx_q    <= '0;
      end else if (vec_done) begin
         role_q   <= pin_role;
         expect_q <= pin_expect;
         idx_q    <= vec_index;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_valid <= 1'b0;
         result_fail  <= 1'b0;
         fault_mask   <= '0;
         alarm        <= 1'b0;
      end else begin
         result_valid <= fire;
         alarm        <= fire && (|mism);
         if (fire) begin
            result_fail <= |mism;
            fault_mask  <= mism;
         end
      end
   end
endmodule

// File: rtl/pin_response_checker_sva.sv
module pin_response_checker_sva #(
   parameter int PINS = 20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            vec_done,
   input logic            result_valid,
   input logic            result_fail,
   input logic [PINS-1:0] fault_mask,
   input logic            alarm,
   input logic            fifo_full,
   input logic            fifo_wr,
   input logic [7:0]      fifo_data,
   input logic            emit_busy
);
   // R1: no result in the cycle right after a start pulse
   assert_no_early_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
      vec_done |=> !result_valid);

   // R3: fail flag agrees with the mask whenever a result is presented
   assert_fail_matches_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (result_fail == (fault_mask != '0)));

   // R5: no write while full, stalled byte held
   assert_no_write_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !fifo_wr);
   assert_stall_holds_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (emit_busy && fifo_full) |=> $stable(fifo_data));

   // R6: alarm only with a failing result, and always with one
   assert_alarm_on_fail_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm |-> (result_valid && result_fail));
   assert_fail_raises_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && result_fail) |-> alarm);
   assert_alarm_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm |=> !alarm);

   // R7: a compare never lands while a record is still being written
   assert_compare_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !$past(emit_busy));
endmodule

bind pin_response_checker pin_response_checker_sva #(.PINS(PINS)) u_sva (
   .clk(clk), .rst_n(rst_n), .vec_done(vec_done), .result_valid(result_valid),
   .result_fail(result_fail), .fault_mask(fault_mask), .alarm(alarm),
   .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
   .emit_busy(emit_busy)
);

// File: tb/test_pin_response_checker.sv
`timescale 1ns/1ps
module test_pin_response_checker;
   localparam int PINS   = 20;
   localparam int IDX_W  = 5;
   localparam int SETTLE = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              vec_done = 1'b0;
   logic [IDX_W-1:0]  vec_index = '0;
   logic [2*PINS-1:0] pin_role = '0;
   logic [2*PINS-1:0] pin_expect = '0;
   logic [PINS-1:0]   pin_in = '0;
   logic              result_valid, result_fail, alarm, fifo_wr;
   logic [PINS-1:0]   fault_mask;
   logic              fifo_full = 1'b0;
   logic [7:0]        fifo_data;

   int n_tests = 0;
   int n_fail  = 0;
   int ncap = 0;
   int n_valid = 0;
   int n_alarm = 0;
   logic [7:0] cap [0:511];
   bit finished = 0;

   always #2 clk = ~clk;

   pin_response_checker #(.PINS(PINS), .IDX_W(IDX_W), .SETTLE_CYC(SETTLE)) i_pin_response_checker (
      .clk(clk), .rst_n(rst_n), .vec_done(vec_done), .vec_index(vec_index),
      .pin_role(pin_role), .pin_expect(pin_expect), .pin_in(pin_in),
      .result_valid(result_valid), .result_fail(result_fail), .fault_mask(fault_mask),
      .alarm(alarm), .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data)
   );

   always @(posedge clk) begin
      if (fifo_wr) begin
         cap[ncap % 512] <= fifo_data;
         ncap <= ncap + 1;
      end
      if (result_valid) n_valid <= n_valid + 1;
      if (alarm) n_alarm <= n_alarm + 1;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R2/R3 arithmetic: compared only when role 10 and level 01 or 10
   function automatic logic [PINS-1:0] want_mask(input logic [2*PINS-1:0] r, input logic [2*PINS-1:0] e,
                                                 input logic [PINS-1:0] p);
      logic [PINS-1:0] m = '0;
      for (int i = 0; i < PINS; i++) begin
         if (r[2*i +: 2] == 2'b10 && (e[2*i +: 2] == 2'b01 || e[2*i +: 2] == 2'b10))
            m[i] = (p[i] != (e[2*i +: 2] == 2'b01));
      end
      return m;
   endfunction

   task automatic check_record(input int base, input int idx, input logic [PINS-1:0] m, input string tag);
      logic [31:0] act, exp;
      exp = {4'b0, m[19:16], m[15:8], m[7:0], 2'b00, idx[4:0], (m != '0)};
      act = {cap[(base+3)%512], cap[(base+2)%512], cap[(base+1)%512], cap[base%512]};
      check(act == exp, {tag, " R4 record bytes"}, act, exp);
   endtask

   task automatic set_vec(input int idx, input logic [2*PINS-1:0] r, input logic [2*PINS-1:0] e,
                          input logic [PINS-1:0] p);
      @(negedge clk);
      vec_index = idx[IDX_W-1:0];
      pin_role = r;
      pin_expect = e;
      pin_in = p;
      repeat (3) @(negedge clk);
   endtask

   // pulse done, then verify the result comes exactly SETTLE edges later (R1)
   task automatic pulse_and_time(input string tag);
      bit early = 0;
      vec_done = 1'b1;
      @(negedge clk);
      vec_done = 1'b0;
      repeat (SETTLE - 1) begin
         @(negedge clk);
         if (result_valid) early = 1;
      end
      @(negedge clk);
      check(!early && result_valid, {tag, " R1 result timing"}, {early, result_valid}, 2'b01);
   endtask

   task automatic run_vec(input int idx, input logic [2*PINS-1:0] r, input logic [2*PINS-1:0] e,
                          input logic [PINS-1:0] p, input string tag);
      int base, al0;
      logic [PINS-1:0] m;
      m = want_mask(r, e, p);
      set_vec(idx, r, e, p);
      base = ncap;
      al0 = n_alarm;
      pulse_and_time(tag);
      check(fault_mask == m, {tag, " R3 fault mask"}, fault_mask, m);
      check(result_fail == (m != '0), {tag, " R3 fail flag"}, result_fail, (m != '0));
      check(alarm == (m != '0), {tag, " R6 alarm with result"}, alarm, (m != '0));
      repeat (8) @(negedge clk);
      check(n_alarm - al0 == ((m != '0) ? 1 : 0), {tag, " R6 alarm count"}, n_alarm - al0, (m != '0));
      check(ncap - base == 4, {tag, " R5 byte count"}, ncap - base, 4);
      check_record(base, idx, m, tag);
   endtask

   initial begin
      logic [2*PINS-1:0] all_out, r, e;
      logic [PINS-1:0] lvl, p;
      int base, v0;
      repeat (3) @(negedge clk);
      check(!result_valid && !result_fail && fault_mask == '0 && !alarm && !fifo_wr,
            "R8 reset state", {result_valid, result_fail, alarm, fifo_wr}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // one-pin-at-a-time sweep over all output pins (R2, R3, R4, R6)
      all_out = '0;
      e = '0;
      lvl = '0;
      for (int i = 0; i < PINS; i++) begin
         all_out[2*i +: 2] = 2'b10;
         e[2*i +: 2] = (i % 2 == 0) ? 2'b01 : 2'b10;
         lvl[i] = (i % 2 == 0);
      end
      run_vec(31, all_out, e, lvl, "all-pass");
      for (int k = 0; k < PINS; k++) begin
         run_vec(k, all_out, e, lvl ^ (PINS'(1) << k), $sformatf("flip pin %0d", k));
      end

      // every role paired with every level, all pins inverted (R2)
      r = '0;
      e = '0;
      lvl = '0;
      for (int i = 0; i < PINS; i++) begin
         r[2*i +: 2] = 2'(i % 4);
         e[2*i +: 2] = 2'((i / 4) % 4);
         lvl[i] = (e[2*i +: 2] == 2'b01);
      end
      run_vec(5, r, e, ~lvl, "role-level cross");
      // no pin is output: every mismatch must be ignored (R2)
      for (int i = 0; i < PINS; i++) r[2*i +: 2] = 2'(i % 2);
      run_vec(9, r, e, ~lvl, "no output pins R2");
      // outputs expecting Z or undetermined only: ignored (R2)
      for (int i = 0; i < PINS; i++) begin
         r[2*i +: 2] = 2'b10;
         e[2*i +: 2] = (i % 2) ? 2'b11 : 2'b00;
      end
      run_vec(12, r, e, {PINS{1'b1}}, "Z and undetermined R2");

      // restart of the settling wait (R1)
      set_vec(3, all_out, {PINS{2'b01}}, '0);
      base = ncap;
      vec_done = 1'b1;
      @(negedge clk);
      vec_done = 1'b0;
      repeat (2) @(negedge clk);
      check(!result_valid, "R1 no result before restart", result_valid, 0);
      pulse_and_time("restart");
      repeat (8) @(negedge clk);
      check(ncap - base == 4, "R1 one record after restart", ncap - base, 4);
      check_record(base, 3, {PINS{1'b1}}, "restart");

      // FIFO full stall with a second compare waiting (R5, R7)
      set_vec(17, all_out, {PINS{2'b10}}, 20'h00005);
      base = ncap;
      v0 = n_valid;
      pulse_and_time("stall A");
      fifo_full = 1'b1;
      @(negedge clk);
      vec_index = 5'd22;
      pin_in = 20'h80000;
      vec_done = 1'b1;
      @(negedge clk);
      vec_done = 1'b0;
      repeat (25) @(negedge clk);
      check(ncap == base, "R5 nothing written while full", ncap - base, 0);
      check(n_valid - v0 == 1, "R7 second compare held", n_valid - v0, 1);
      fifo_full = 1'b0;
      repeat (3) @(negedge clk);
      fifo_full = 1'b1;
      repeat (4) @(negedge clk);
      fifo_full = 1'b0;
      repeat (30) @(negedge clk);
      check(ncap - base == 8, "R5 R7 all bytes of both records", ncap - base, 8);
      check(n_valid - v0 == 2, "R7 second compare done", n_valid - v0, 2);
      check_record(base, 17, 20'h00005, "stall A");
      check_record(base + 4, 22, 20'h80000, "stall B");

      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=expired expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule